// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block feeds the data path of a card host with word addresses for a transfer. A transfer is either one contiguous buffer or a chain of buffers described by three-word descriptors in memory. The first descriptor is loaded by register writes before the start. Every later descriptor is read over a simple memory-read port at the list base address plus the byte offset held in the previous link word. Each buffer is turned into a stream of 32-bit word beats, and each beat carries its address and byte enables. The data path moves the data in either direction and accepts beats over a valid/ready handshake.

A descriptor in memory holds three words at increasing addresses. The first is the link word, the second the buffer base address, the third the buffer size in bytes. Three flags sit in the top bits of the link word. Bit 31 means another descriptor follows. Bit 30 means the following descriptor's size word is to be read. Bit 29 asks for a buffer-ready acknowledge when this buffer completes. Each buffer is checked for alignment before any of its beats leave. A violation stops the engine and leaves a sticky error flag set. A clean finish gives a one-cycle done pulse.

Back-pressure on the beat stream: a beat is transferred in a cycle where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low, the beat on offer holds its address, byte enables and last flag. The memory-read port works the same way on its request side. Its response comes back on `mrd_rvalid` and cannot be stalled.

Top module: `lldma_engine`

## Requirements
- R1: After reset `busy`, `done`, `err`, `buf_ack`, `xfer_valid` and `mrd_valid` are all low.
- R2: The register port has five addresses. 0 is control (bit 0 run, bit 1 list mode), 1 is the list base, 2 the first link word, 3 the first base, 4 the first size. A control write with bit 0 set starts a transfer only while idle, and `busy` is high from the second cycle after that write. A control write with bit 0 clear while idle starts nothing.
- R3: A buffer of S bytes at base B gives ceil(S/4) beats, with addresses B, B+4, and so on. Every beat except the final one has byte enables 4'hF. The final beat enables the low S-4*(ceil(S/4)-1) bytes, and `xfer_last` marks it. A buffer of size 0 gives no beats.
- R4: While `xfer_valid` is high and `xfer_ready` is low, the offered beat stays unchanged.
- R5: With list mode off, or with bit 31 of the first link word clear, only the first buffer is moved and the memory port stays unused.
- R6: After a buffer whose link word has bit 31 set, the engine reads the next link word at list base plus link bits [15:0], and then the base word at +4. It reads the size word at +8 only if bit 30 of the previous link word was set. Otherwise the previous size is kept.
- R7: A descriptor whose link word has bit 31 clear is the last one. The engine returns to idle after that buffer's final beat.
- R8: A buffer with a base not 32-bit aligned raises `err` and emits no beats. So does a non-last buffer whose size is not a multiple of BURST_BYTES. The last buffer needs only an aligned base.
- R9: `err` stays high until the next start, which clears it, and no done pulse follows an error.
- R10: `done` pulses for exactly one cycle, in the cycle after the final beat of the final buffer is accepted.
- R11: In list mode, `buf_ack` pulses once when a buffer whose link word has bit 29 set completes.
- R12: A control write of zero while busy makes the buffer in progress the last one, and the transfer then ends with done. A nonzero control write while busy has no effect.
- R13: A memory request holds its address until accepted, at most one read is outstanding, and requests and beats are never offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wr_data | input | 32 | Register write data |
| mrd_valid | output | 1 | Descriptor read request valid |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_addr | output | ADDR_W | Descriptor word address |
| mrd_rvalid | input | 1 | Read data returned |
| mrd_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Beat offered to the data path |
| xfer_ready | input | 1 | Data path accepts the beat |
| xfer_addr | output | ADDR_W | Word address of the beat |
| xfer_be | output | 4 | Byte enables of the beat |
| xfer_last | output | 1 | Final beat of the current buffer |
| buf_ack | output | 1 | Buffer-ready acknowledge pulse |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Sticky alignment error |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps buffer sizes across every partial-word tail and chains of two to four descriptors with every pattern of the size-update bit. An engine that miscounts the tail would give wrong byte enables or one beat too many. One that ignores the update bit would stream the wrong length or read an extra memory word. The bench also places misaligned bases and sizes in the first, middle and last positions of a chain. A wrong check would either stream the bad buffer or flag a legal last buffer. It also exercises stop and nonzero control writes in the middle of a stream, under both free-flowing and stalling ready patterns. A design that lost a beat while stalled, or honoured a restart while busy, would show a beat-list mismatch.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  // flag positions inside the three-bit flag group taken from link bits [31:29]
  localparam int FL_MORE  = 2;  // another descriptor follows
  localparam int FL_NEWSZ = 1;  // read the next descriptor's size word
  localparam int FL_ACK   = 0;  // pulse buffer acknowledge on completion
  localparam int FLAG_LSB = 29;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_LIST = 3'd1;
  localparam logic [2:0] RA_LINK = 3'd2;
  localparam logic [2:0] RA_BASE = 3'd3;
  localparam logic [2:0] RA_SIZE = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_STREAM = 2'd2,
    ST_FETCH  = 2'd3
  } eng_state_t;

  // byte enables for a final word holding n bytes (n = 1..4, 4 coded as 3'b100)
  function automatic logic [3:0] tail_mask(input logic [2:0] n);
    case (n)
      3'd1:    tail_mask = 4'b0001;
      3'd2:    tail_mask = 4'b0011;
      3'd3:    tail_mask = 4'b0111;
      default: tail_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              busy,
  output logic [ADDR_W-1:0] list_base,
  output logic [2:0]        first_flags,
  output logic [OFS_W-1:0]  first_ofs,
  output logic [ADDR_W-1:0] first_base,
  output logic [SIZE_W-1:0] first_size,
  output logic              list_mode,
  output logic              start_pulse,
  output logic              stop_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_base   <= '0;
      first_flags <= '0;
      first_ofs   <= '0;
      first_base  <= '0;
      first_size  <= '0;
      list_mode   <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            if (busy) begin
              // R12: only an all-zero write matters while running
              if (wr_data == 32'd0) stop_pulse <= 1'b1;
            end else if (wr_data[0]) begin
              start_pulse <= 1'b1;
              list_mode   <= wr_data[1];
            end
          end
          RA_LIST: list_base  <= wr_data[ADDR_W-1:0];
          RA_LINK: begin
            first_flags <= wr_data[FLAG_LSB+2:FLAG_LSB];
            first_ofs   <= wr_data[OFS_W-1:0];
          end
          RA_BASE: first_base <= wr_data[ADDR_W-1:0];
          RA_SIZE: first_size <= wr_data[SIZE_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lldma_fetch.sv
module lldma_fetch
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] list_base,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              want_size,
  input  logic [SIZE_W-1:0] size_in,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrd_rvalid,
  input  logic [31:0]       mrd_rdata,
  output logic              fin,
  output logic [2:0]        out_flags,
  output logic [OFS_W-1:0]  out_ofs,
  output logic [ADDR_W-1:0] out_base,
  output logic [SIZE_W-1:0] out_size
);
  logic [ADDR_W-1:0] desc_addr;
  logic [1:0]        idx;
  logic              active;
  logic              waiting;
  logic              need_size;
  logic              final_word;

  assign mrd_valid  = active && !waiting;
  assign mrd_addr   = desc_addr + ADDR_W'({idx, 2'b00});
  assign final_word = (idx == 2'd2) || (idx == 2'd1 && !need_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_addr <= '0;
      idx       <= '0;
      active    <= 1'b0;
      waiting   <= 1'b0;
      need_size <= 1'b0;
      fin       <= 1'b0;
      out_flags <= '0;
      out_ofs   <= '0;
      out_base  <= '0;
      out_size  <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active    <= 1'b1;
        waiting   <= 1'b0;
        idx       <= 2'd0;
        desc_addr <= list_base + ADDR_W'(ofs_in);
        need_size <= want_size;
        out_size  <= size_in;  // carried over unless the size word is read
      end else if (active) begin
        if (!waiting) begin
          if (mrd_ready) waiting <= 1'b1;
        end else if (mrd_rvalid) begin
          case (idx)
            2'd0: begin
              out_flags <= mrd_rdata[FLAG_LSB+2:FLAG_LSB];
              out_ofs   <= mrd_rdata[OFS_W-1:0];
            end
            2'd1:    out_base <= mrd_rdata[ADDR_W-1:0];
            default: out_size <= mrd_rdata[SIZE_W-1:0];
          endcase
          if (final_word) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            idx     <= idx + 2'd1;
            waiting <= 1'b0;
          end
        end
      end
    end
  end

  // R13: a pending request keeps its address until accepted
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));
endmodule

// File: rtl/lldma_beat.sv
module lldma_beat
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [3:0]        xfer_be,
  output logic              xfer_last,
  output logic              buf_end
);
  logic [ADDR_W-1:0] ptr;
  logic [SIZE_W-1:0] rem;
  logic              active;

  assign xfer_valid = active;
  assign xfer_addr  = ptr;
  assign xfer_last  = rem <= SIZE_W'(4);
  assign xfer_be    = xfer_last ? tail_mask(rem[2:0]) : 4'hF;
  assign buf_end    = active && xfer_ready && xfer_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      rem    <= '0;
      active <= 1'b0;
    end else if (load) begin
      ptr    <= base;
      rem    <= size;
      active <= size != '0;
    end else if (active && xfer_ready) begin
      if (xfer_last) begin
        active <= 1'b0;
      end else begin
        ptr <= ptr + ADDR_W'(4);
        rem <= rem - SIZE_W'(4);
      end
    end
  end

  // R4: an offered beat is held while the sink stalls
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_be) && $stable(xfer_last));
  // R3: beats are word aligned
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr[1:0] == 2'b00);
  // R3: only the final beat of a buffer may be partial
  a_r3_full_inner: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_last |-> xfer_be == 4'hF);
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 24,
  parameter int OFS_W       = 16,
  parameter int BURST_BYTES = 16   // power of two
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wr_data,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrd_rvalid,
  input  logic [31:0]       mrd_rdata,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [3:0]        xfer_be,
  output logic              xfer_last,
  output logic              buf_ack,
  output logic              done,
  output logic              err,
  output logic              busy
);
  localparam logic [SIZE_W-1:0] BURST_MASK = SIZE_W'(BURST_BYTES - 1);

  eng_state_t        state;
  logic [2:0]        cur_flags;
  logic [OFS_W-1:0]  cur_ofs;
  logic [ADDR_W-1:0] cur_base;
  logic [SIZE_W-1:0] cur_size;
  logic              stop_flag;

  logic [ADDR_W-1:0] list_base, first_base, f_base;
  logic [2:0]        first_flags, f_flags;
  logic [OFS_W-1:0]  first_ofs, f_ofs;
  logic [SIZE_W-1:0] first_size, f_size;
  logic              list_mode, start_pulse, stop_pulse;
  logic              f_fin, buf_end;
  logic              is_last, bad, beat_load, fetch_go;

  assign busy    = state != ST_IDLE;
  assign is_last = !list_mode || !cur_flags[FL_MORE] || stop_flag;
  assign bad     = (cur_base[1:0] != 2'b00)
                || (!is_last && ((cur_size & BURST_MASK) != '0));
  assign beat_load = (state == ST_CHECK) && !bad && (cur_size != '0);
  assign fetch_go  = ((state == ST_CHECK) && !bad && (cur_size == '0) && !is_last)
                  || ((state == ST_STREAM) && buf_end && !is_last);

  lldma_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wr_data), .busy(busy), .list_base(list_base),
    .first_flags(first_flags), .first_ofs(first_ofs), .first_base(first_base),
    .first_size(first_size), .list_mode(list_mode),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  lldma_fetch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .list_base(list_base),
    .ofs_in(cur_ofs), .want_size(cur_flags[FL_NEWSZ]), .size_in(cur_size),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .fin(f_fin),
    .out_flags(f_flags), .out_ofs(f_ofs), .out_base(f_base), .out_size(f_size)
  );

  lldma_beat #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(beat_load), .base(cur_base),
    .size(cur_size), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_be(xfer_be), .xfer_last(xfer_last),
    .buf_end(buf_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_flags <= '0;
      cur_ofs   <= '0;
      cur_base  <= '0;
      cur_size  <= '0;
      stop_flag <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      buf_ack   <= 1'b0;
    end else begin
      done    <= 1'b0;
      buf_ack <= 1'b0;
      if (stop_pulse) stop_flag <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_pulse) begin
            cur_flags <= first_flags;
            cur_ofs   <= first_ofs;
            cur_base  <= first_base;
            cur_size  <= first_size;
            stop_flag <= 1'b0;
            err       <= 1'b0;
            state     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (bad) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (cur_size == '0) begin
            buf_ack <= list_mode && cur_flags[FL_ACK];
            if (is_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end else begin
            state <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (buf_end) begin
            buf_ack <= list_mode && cur_flags[FL_ACK];
            if (is_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (f_fin) begin
            cur_flags <= f_flags;
            cur_ofs   <= f_ofs;
            cur_base  <= f_base;
            cur_size  <= f_size;
            state     <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: never a request and a beat together
  a_r13_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrd_valid && xfer_valid));
  // R9: error holds until a new start
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start_pulse |=> err);
  // R10: done only while returning idle without error
  a_r10_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);
  // R8: an error never coincides with an offered beat
  a_r8_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !xfer_valid);
  // R8: a rejected buffer is never loaded into the beat generator
  a_r8_bad_not_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) && bad |=> !xfer_valid && !busy);
endmodule

// File: tb/sim_lldma_engine.sv
module sim_lldma_engine;
  localparam int BURST = 16;
  localparam logic [31:0] LIST_BASE = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic tb_wr_en = 1'b0;
  logic [2:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic stop_wr = 1'b0;
  logic [31:0] stop_val = '0;
  logic reg_wr_en;
  logic [2:0] reg_addr;
  logic [31:0] reg_wr_data;
  assign reg_wr_en   = tb_wr_en | stop_wr;
  assign reg_addr    = stop_wr ? 3'd0 : tb_addr;
  assign reg_wr_data = stop_wr ? stop_val : tb_data;

  logic mrd_valid, mrd_ready, mrd_rvalid;
  logic [31:0] mrd_addr, mrd_rdata;
  logic xfer_valid, xfer_ready, xfer_last, buf_ack, done, err, busy;
  logic [31:0] xfer_addr;
  logic [3:0] xfer_be;

  initial begin
    mrd_ready = 1'b0; mrd_rvalid = 1'b0; mrd_rdata = '0; xfer_ready = 1'b0;
  end

  lldma_engine #(.BURST_BYTES(BURST)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready),
    .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_be(xfer_be), .xfer_last(xfer_last), .buf_ack(buf_ack), .done(done),
    .err(err), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:63];
  int cyc = 0;
  bit pend = 0;
  logic [31:0] pend_a = '0;
  int mem_reads = 0, done_cnt = 0, ack_cnt = 0, cap_n = 0;
  int last_beat_cyc = 0, done_cyc = 0;
  bit bp = 0;
  int stop_at = -1;
  int stop_arm = 0, stop_fired = 0;
  logic [31:0] cap_addr [0:1023];
  logic [3:0]  cap_be   [0:1023];
  logic        cap_last [0:1023];

  // memory model, data sink and event counters, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      mrd_rvalid = 1'b1; mrd_rdata = mem[pend_a[7:2]]; pend = 0;
    end else begin
      mrd_rvalid = 1'b0;
    end
    mrd_ready = bp ? ((cyc % 3) != 1) : 1'b1;
    if (mrd_valid && mrd_ready) begin
      pend = 1; pend_a = mrd_addr; mem_reads++;
    end
    xfer_ready = bp ? (((cyc * 7) % 5) != 0) : 1'b1;
    if (xfer_valid && xfer_ready) begin
      cap_addr[cap_n % 1024] = xfer_addr;
      cap_be[cap_n % 1024]   = xfer_be;
      cap_last[cap_n % 1024] = xfer_last;
      cap_n++;
      if (xfer_last) last_beat_cyc = cyc;
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (buf_ack) ack_cnt++;
    stop_wr = 1'b0;
    if (stop_fired != stop_arm && stop_at >= 0 && busy && cap_n >= stop_at) begin
      stop_wr = 1'b1; stop_fired = stop_arm;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_wr_en = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_wr_en = 1'b0;
  endtask

  // case description
  int n_desc;
  bit ll;
  logic [31:0] lk [0:7];
  logic [31:0] bs [0:7];
  logic [31:0] sz [0:7];
  int stop_beat;
  logic [31:0] stop_word;
  logic [31:0] ea [0:1023];
  logic [3:0]  ebe [0:1023];
  logic        elast [0:1023];

  task automatic run_case(input string name);
    int exp_n, exp_ack, exp_reads, c0, d0, a0, m0, got, mism, eff, wait_c;
    bit exp_err, last;
    exp_n = 0; exp_ack = 0; exp_reads = 0; exp_err = 0; eff = sz[0];
    for (int i = 0; i < n_desc; i++) begin
      if (i > 0) begin
        exp_reads += lk[i-1][30] ? 3 : 2;
        if (lk[i-1][30]) eff = sz[i];
      end
      last = !ll || !lk[i][31] || (stop_beat >= 0 && stop_word == 0 && i == 0);
      if (bs[i][1:0] != 2'b00 || (!last && (eff % BURST) != 0)) begin
        exp_err = 1; break;
      end
      for (int w = 0; w * 4 < eff; w++) begin
        int rem;
        rem = eff - w * 4;
        ea[exp_n]    = bs[i] + 32'(w * 4);
        ebe[exp_n]   = rem >= 4 ? 4'hF : (rem == 3 ? 4'h7 : (rem == 2 ? 4'h3 : 4'h1));
        elast[exp_n] = rem <= 4;
        exp_n++;
      end
      if (ll && lk[i][29]) exp_ack++;
      if (last) break;
    end
    for (int i = 1; i < n_desc; i++) begin
      mem[(LIST_BASE + 32'(i * 12)) >> 2]     = lk[i];
      mem[(LIST_BASE + 32'(i * 12) + 4) >> 2] = bs[i];
      mem[(LIST_BASE + 32'(i * 12) + 8) >> 2] = sz[i];
    end
    wr_reg(3'd1, LIST_BASE);
    wr_reg(3'd2, lk[0]);
    wr_reg(3'd3, bs[0]);
    wr_reg(3'd4, sz[0]);
    c0 = cap_n; d0 = done_cnt; a0 = ack_cnt; m0 = mem_reads;
    stop_val = stop_word;
    stop_at = stop_beat >= 0 ? c0 + stop_beat : -1;
    stop_arm++;
    wr_reg(3'd0, {30'd0, ll, 1'b1});
    @(negedge clk);
    chk(err == 1'b0, {"R9 err cleared at start ", name}, err, 0);
    chk(busy == 1'b1 || exp_n == 0, {"R2 busy after start ", name}, busy, 1);
    wait_c = 0;
    while (done_cnt == d0 && !err && wait_c < 5000) begin
      @(negedge clk); wait_c++;
    end
    repeat (4) @(negedge clk);
    stop_at = -1;
    got = cap_n - c0;
    chk(got == exp_n, {"R3 R6 beat count ", name}, got, exp_n);
    mism = 0;
    for (int k = 0; k < exp_n && k < got; k++) begin
      int ix;
      ix = (c0 + k) % 1024;
      if (cap_addr[ix] != ea[k] || cap_be[ix] != ebe[k] || cap_last[ix] != elast[k]) mism++;
    end
    chk(mism == 0, {"R3 R4 beat contents ", name}, mism, 0);
    chk(err == exp_err, {"R8 R9 error flag ", name}, err, exp_err);
    chk(done_cnt - d0 == (exp_err ? 0 : 1), {"R7 R10 done count ", name}, done_cnt - d0, exp_err ? 0 : 1);
    chk(ack_cnt - a0 == exp_ack, {"R11 ack count ", name}, ack_cnt - a0, exp_ack);
    chk(mem_reads - m0 == exp_reads, {"R5 R6 R13 memory reads ", name}, mem_reads - m0, exp_reads);
    if (!exp_err && exp_n > 0)
      chk(done_cyc == last_beat_cyc + 1, {"R10 done timing ", name}, done_cyc, last_beat_cyc + 1);
    chk(busy == 1'b0, {"R7 idle at end ", name}, busy, 0);
  endtask

  initial begin
    int m0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    stop_beat = -1; stop_word = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !buf_ack && !xfer_valid && !mrd_valid,
        "R1 reset state", {busy, done, err, buf_ack, xfer_valid, mrd_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: control write without the run bit does nothing while idle
    m0 = mem_reads;
    wr_reg(3'd0, 32'h2);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_reads == m0, "R2 no start without run bit", busy, 0);

    // R3 R5: single mode, every size 0..24, link flags ignored
    for (int s = 0; s <= 24; s++) begin
      n_desc = 1; ll = 0; bp = s[0];
      lk[0] = 32'hE000_000C; bs[0] = 32'h1000 + 32'(s * 64); sz[0] = 32'(s);
      run_case($sformatf("single size %0d", s));
    end
    // R8: misaligned base in single mode
    for (int o = 1; o < 4; o++) begin
      n_desc = 1; ll = 0; bp = 0;
      lk[0] = 32'h0; bs[0] = 32'h1800 + 32'(o); sz[0] = 32'd8;
      run_case($sformatf("single misaligned %0d", o));
    end
    // R5 R11: list mode but first link ends the list
    n_desc = 1; ll = 1; bp = 1;
    lk[0] = 32'h2000_000C; bs[0] = 32'h1900; sz[0] = 32'd13;
    run_case("list mode single");

    // R6 R7 R11: chains of 2..4 with every size-update pattern
    for (int n = 2; n <= 4; n++) begin
      for (int pat = 0; pat < (1 << (n - 1)); pat++) begin
        for (int b = 0; b < 2; b++) begin
          n_desc = n; ll = 1; bp = b[0];
          for (int i = 0; i < n; i++) begin
            bs[i] = 32'h2000 + 32'(i * 256);
            sz[i] = (i == n - 1) ? 32'(5 + n) : 32'(16 * (i + 1));
            if (i < n - 1)
              lk[i] = 32'h8000_0000 | (32'((pat >> i) & 1) << 30)
                    | (32'((i + pat) & 1) << 29) | 32'((i + 1) * 12);
            else
              lk[i] = (32'(pat & 1) << 29) | 32'h4000_0000;
          end
          run_case($sformatf("chain n%0d pat%0d bp%0d", n, pat, b));
        end
      end
    end

    // R8: alignment faults in chains
    n_desc = 3; ll = 1; bp = 0;
    for (int i = 0; i < 3; i++) begin
      bs[i] = 32'h3000 + 32'(i * 256); sz[i] = 32'd32;
      lk[i] = (i < 2) ? (32'hE000_0000 | 32'((i + 1) * 12)) : 32'h0;
    end
    sz[1] = 32'd20;
    run_case("middle size not burst multiple");
    sz[1] = 32'd32; bs[2] = 32'h3202;
    run_case("last base misaligned");
    bs[2] = 32'h3200; bs[1] = 32'h3101;
    run_case("middle base misaligned");
    bs[1] = 32'h3100; sz[0] = 32'd20;
    run_case("first size not burst multiple");
    sz[0] = 32'd32; sz[2] = 32'd7; bp = 1;
    run_case("last size any length");

    // R12: stop mid-buffer, and nonzero control writes ignored while busy
    stop_beat = 2; stop_word = 32'h0;
    run_case("stop during first buffer");
    stop_word = 32'h3;
    run_case("nonzero control while busy");
    stop_word = 32'h1; bp = 0;
    run_case("run bit while busy");
    stop_beat = -1;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule